// File: doc/BRIEF.md
# Wide-to-Narrow Register Bus Bridge

This block lets a Wishbone classic master reach a bank of registers that sit on a narrow strobed register bus. The master side carries a word of `WB_DW` bits; the register side carries `CSR_DW` bits. When the master word is wider than the register bus, the bridge cuts it into several lanes of `CSR_DW` bits each. It then runs one register beat per lane. The lowest lane goes first, and lane k goes to register address `wb_adr * LANES + k`. When the two widths are the same there is only one lane, and the master word address is the register address.

The byte selects pick the lanes that take part. A lane whose select bits are all clear gets no beat at all, on a write or on a read. On a read, the register bus returns data one cycle after the beat's address and read strobe. The bridge collects these pieces into a word. Every byte whose select bit is clear reads as zero. The master sees a single-cycle `wb_ack` once all lanes are done. The cycle count of an access is fixed and does not depend on the byte selects.

The register bus width may only be 8, 16, 32 or 64 bits, and the master width must be a power-of-two multiple of it. Any other pair of values stops elaboration.

Top module: `wbcsr_bridge`

## Requirements
- R1: After reset, `wb_ack`, `csr_r_stb` and `csr_w_stb` are low and `wb_dat_r` is zero.
- R2: An access starts only at a clock edge where `wb_cyc` and `wb_stb` are both high and the bridge is idle. With either one low, the bridge issues no strobe and no acknowledge.
- R3: Lane k (k = 0 .. LANES-1) is handled in cycle k+1 after the accepting edge. Its beat presents address `wb_adr*LANES + k` and, on a write, data bits `[k*CSR_DW +: CSR_DW]` of the sampled `wb_dat_w`. Beats therefore run least significant lane first, in consecutive cycles.
- R4: On a write, a lane with at least one set select bit is written whole with one `csr_w_stb`. A lane with all select bits clear produces no write strobe, and its register keeps its value.
- R5: On a read, a lane with all select bits clear produces no `csr_r_stb`.
- R6: On a read, every byte of `wb_dat_r` in the ack cycle is either zero (select bit clear) or the matching byte of `csr_r_data`, taken one cycle after that lane's beat.
- R7: `wb_ack` is high for exactly one cycle. That cycle is cycle LANES+2 after the accepting edge: one cycle per lane, one finishing cycle, then the ack.
- R8: `csr_r_stb` and `csr_w_stb` are never high together, and neither is high in the ack cycle.
- R9: With `WB_DW == CSR_DW`, each access is one beat to register address `wb_adr`, acknowledged in cycle 3.
- R10: An access with all select bits clear makes no register beat, still acknowledges at the R7 cycle, and on a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Master cycle valid |
| wb_stb | input | 1 | Master strobe |
| wb_we | input | 1 | Write enable (1 = write) |
| wb_adr | input | WB_AW | Master word address |
| wb_sel | input | WB_DW/8 | Byte selects, bit i covers byte i |
| wb_dat_w | input | WB_DW | Master write data |
| wb_dat_r | output | WB_DW | Assembled read data, valid in the ack cycle |
| wb_ack | output | 1 | Single-cycle acknowledge |
| csr_addr | output | WB_AW+log2(WB_DW/CSR_DW) | Register address of the current beat |
| csr_r_stb | output | 1 | Register read strobe |
| csr_w_stb | output | 1 | Register write strobe |
| csr_w_data | output | CSR_DW | Register write data for the current lane |
| csr_r_data | input | CSR_DW | Register read data, one cycle after the read strobe |

## Verification
The bench builds two copies of the bridge. The main copy uses `WB_DW=32`, `CSR_DW=8` and `WB_AW=4`. Its four byte lanes make it possible to check lane order, skipped lanes on both directions, partial selects, per-byte zeroing on reads, and the top address, where the lane index fills the low register address bits. The second copy uses `WB_DW=CSR_DW=16`. It covers the one-lane case, where there are no lane bits, only one beat runs, and the ack arrives in cycle 3.

// File: rtl/wbcsr_pkg.sv
package wbcsr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BEAT = 2'd1,
        SEQ_FIN  = 2'd2,
        SEQ_ACK  = 2'd3
    } seq_state_e;

    function automatic bit csr_width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/wbcsr_lane_map.sv
// Turns byte selects into a per-lane enable and a per-bit byte mask.
module wbcsr_lane_map #(
    parameter int WB_DW  = 32,
    parameter int CSR_DW = 8
) (
    input  logic [WB_DW/8-1:0]      sel,
    output logic [WB_DW/CSR_DW-1:0] lane_en,
    output logic [WB_DW-1:0]        byte_mask
);
    localparam int SEL_W = WB_DW / 8;
    localparam int LANES = WB_DW / CSR_DW;
    localparam int BPL   = CSR_DW / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_en[k] = |sel[k*BPL +: BPL];
    end

    for (genvar b = 0; b < SEL_W; b++) begin : g_byte
        assign byte_mask[b*8 +: 8] = {8{sel[b]}};
    end
endmodule

// File: rtl/wbcsr_seq.sv
// Access sequencer: idle -> one beat per lane -> finish -> ack.
module wbcsr_seq #(
    parameter int LANES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    output logic                                   idle,
    output logic                                   in_beat,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] lane,
    output logic                                   ack
);
    import wbcsr_pkg::*;

    localparam int LANE_CW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_CW-1:0] LAST_LANE = LANE_CW'(LANES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [LANE_CW-1:0] lane;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.st   = SEQ_BEAT;
                    seq_d.lane = '0;
                end
            end
            SEQ_BEAT: begin
                if (seq_q.lane == LAST_LANE) begin
                    seq_d.st = SEQ_FIN;
                end else begin
                    seq_d.lane = seq_q.lane + 1'b1;
                end
            end
            SEQ_FIN:  seq_d.st = SEQ_ACK;
            SEQ_ACK:  seq_d.st = SEQ_IDLE;
            default:  seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= SEQ_IDLE;
            seq_q.lane <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle    = (seq_q.st == SEQ_IDLE);
    assign in_beat = (seq_q.st == SEQ_BEAT);
    assign ack     = (seq_q.st == SEQ_ACK);
    assign lane    = seq_q.lane;
endmodule

// File: rtl/wbcsr_rd_collect.sv
// Gathers read lanes into the wide word, masking unselected bytes.
module wbcsr_rd_collect #(
    parameter int WB_DW  = 32,
    parameter int CSR_DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 cap_en,
    input  logic [((WB_DW/CSR_DW > 1) ? $clog2(WB_DW/CSR_DW) : 1)-1:0] cap_lane,
    input  logic [CSR_DW-1:0]    r_data,
    input  logic [WB_DW-1:0]     byte_mask,
    output logic [WB_DW-1:0]     word
);
    logic [WB_DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clear) begin
            word_d = '0;
        end else if (cap_en) begin
            word_d[int'(cap_lane)*CSR_DW +: CSR_DW] =
                r_data & byte_mask[int'(cap_lane)*CSR_DW +: CSR_DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/wbcsr_bridge.sv
module wbcsr_bridge #(
    parameter int WB_DW  = 32,
    parameter int CSR_DW = 8,
    parameter int WB_AW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_cyc,
    input  logic                 wb_stb,
    input  logic                 wb_we,
    input  logic [WB_AW-1:0]     wb_adr,
    input  logic [WB_DW/8-1:0]   wb_sel,
    input  logic [WB_DW-1:0]     wb_dat_w,
    output logic [WB_DW-1:0]     wb_dat_r,
    output logic                 wb_ack,
    output logic [WB_AW+$clog2(WB_DW/CSR_DW)-1:0] csr_addr,
    output logic                 csr_r_stb,
    output logic                 csr_w_stb,
    output logic [CSR_DW-1:0]    csr_w_data,
    input  logic [CSR_DW-1:0]    csr_r_data
);
    import wbcsr_pkg::*;

    localparam int SEL_W     = WB_DW / 8;
    localparam int LANES     = WB_DW / CSR_DW;
    localparam int LANE_BITS = $clog2(LANES);
    localparam int LANE_CW   = (LANES > 1) ? LANE_BITS : 1;

    if (!csr_width_ok(CSR_DW) || (WB_DW % CSR_DW) != 0 || !is_pow2(LANES))
    begin : g_bad_cfg
        $error("wbcsr_bridge: register width must be 8/16/32/64 and divide the master width by a power of two");
    end

    typedef struct packed {
        logic [WB_AW-1:0]   adr;
        logic               we;
        logic [SEL_W-1:0]   sel;
        logic [WB_DW-1:0]   dat;
        logic               pend_v;
        logic [LANE_CW-1:0] pend_lane;
    } top_reg_t;

    top_reg_t r_d, r_q;

    logic               seq_idle;
    logic               seq_beat;
    logic [LANE_CW-1:0] seq_lane;
    logic               seq_ack;
    logic               start;
    logic [LANES-1:0]   lane_en;
    logic [WB_DW-1:0]   byte_mask;
    logic               beat_go;

    assign start = wb_cyc && wb_stb && seq_idle;

    wbcsr_seq #(
        .LANES (LANES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .idle    (seq_idle),
        .in_beat (seq_beat),
        .lane    (seq_lane),
        .ack     (seq_ack)
    );

    wbcsr_lane_map #(
        .WB_DW  (WB_DW),
        .CSR_DW (CSR_DW)
    ) u_lane_map (
        .sel       (r_q.sel),
        .lane_en   (lane_en),
        .byte_mask (byte_mask)
    );

    wbcsr_rd_collect #(
        .WB_DW  (WB_DW),
        .CSR_DW (CSR_DW)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .cap_en    (r_q.pend_v),
        .cap_lane  (r_q.pend_lane),
        .r_data    (csr_r_data),
        .byte_mask (byte_mask),
        .word      (wb_dat_r)
    );

    assign beat_go = seq_beat && lane_en[seq_lane];

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.adr = wb_adr;
            r_d.we  = wb_we;
            r_d.sel = wb_sel;
            r_d.dat = wb_dat_w;
        end
        r_d.pend_v    = beat_go && !r_q.we;
        r_d.pend_lane = seq_lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    if (LANES == 1) begin : g_addr_direct
        assign csr_addr = r_q.adr;
    end else begin : g_addr_lane
        assign csr_addr = {r_q.adr, seq_lane};
    end

    assign csr_r_stb  = beat_go && !r_q.we;
    assign csr_w_stb  = beat_go && r_q.we;
    assign csr_w_data = r_q.dat[int'(seq_lane)*CSR_DW +: CSR_DW];
    assign wb_ack     = seq_ack;
endmodule

// File: rtl/wbcsr_bridge_chk.sv
module wbcsr_bridge_chk #(
    parameter int WB_DW  = 32,
    parameter int CSR_DW = 8
) (
    input logic clk,
    input logic rst_n,
    input logic wb_cyc,
    input logic wb_stb,
    input logic wb_ack,
    input logic csr_r_stb,
    input logic csr_w_stb
);
    localparam int LANES  = WB_DW / CSR_DW;
    localparam int ACK_AT = LANES + 1;

    logic        busy;
    logic [15:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (wb_cyc && wb_stb) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else begin
            if (wb_ack) busy <= 1'b0;
            cnt <= cnt + 16'd1;
        end
    end

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    assert_ack_on_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> (busy && (int'(cnt) == ACK_AT)));

    assert_ack_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (int'(cnt) == ACK_AT)) |-> wb_ack);

    assert_beat_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_r_stb || csr_w_stb) |-> (busy && (int'(cnt) < LANES)));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_r_stb && csr_w_stb) && !(wb_ack && (csr_r_stb || csr_w_stb)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!csr_r_stb && !csr_w_stb && !wb_ack));
endmodule

bind wbcsr_bridge wbcsr_bridge_chk #(
    .WB_DW  (WB_DW),
    .CSR_DW (CSR_DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_ack    (wb_ack),
    .csr_r_stb (csr_r_stb),
    .csr_w_stb (csr_w_stb)
);

// File: tb/wbcsr_bridge_tb.sv
module wbcsr_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_A = 6;   // 4 lanes + finish + ack
    localparam int LAT_B = 3;   // 1 lane + finish + ack

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // ---------------- instance A: 32 over 8 ----------------
    logic        cyc = 0, stb = 0, we = 0;
    logic [3:0]  adr = '0;
    logic [3:0]  sel = '0;
    logic [31:0] dw = '0;
    logic [31:0] dr;
    logic        ack;
    logic [5:0]  caddr;
    logic        rstb, wstb;
    logic [7:0]  cwd, crd;

    wbcsr_bridge #(.WB_DW(32), .CSR_DW(8), .WB_AW(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
        .wb_adr(adr), .wb_sel(sel), .wb_dat_w(dw), .wb_dat_r(dr), .wb_ack(ack),
        .csr_addr(caddr), .csr_r_stb(rstb), .csr_w_stb(wstb),
        .csr_w_data(cwd), .csr_r_data(crd)
    );

    logic [7:0] mem [64];
    int wcnt [64];
    int rcnt [64];
    int tick = 0;
    int log_n = 0;
    int log_addr [256];
    int log_tick [256];
    int viol = 0;
    int any_stb = 0;
    int any_ack = 0;

    always @(posedge clk) begin
        tick <= tick + 1;
        if (!rst_n) begin
            crd <= '0;
            for (int i = 0; i < 64; i++) begin
                mem[i] <= '0; wcnt[i] <= 0; rcnt[i] <= 0;
            end
        end else begin
            if (wstb) begin
                mem[caddr] <= cwd;
                wcnt[caddr] <= wcnt[caddr] + 1;
            end
            if (rstb) begin
                crd <= mem[caddr];
                rcnt[caddr] <= rcnt[caddr] + 1;
            end
            if ((rstb || wstb) && log_n < 256) begin
                log_addr[log_n] <= int'(caddr);
                log_tick[log_n] <= tick;
                log_n <= log_n + 1;
            end
            if ((rstb && wstb) || (ack && (rstb || wstb))) viol <= viol + 1;
            if (rstb || wstb) any_stb <= any_stb + 1;
            if (ack) any_ack <= any_ack + 1;
        end
    end

    // ---------------- instance B: 16 over 16 ----------------
    logic        b_cyc = 0, b_stb = 0, b_we = 0;
    logic [3:0]  b_adr = '0;
    logic [1:0]  b_sel = '0;
    logic [15:0] b_dw = '0;
    logic [15:0] b_dr;
    logic        b_ack;
    logic [3:0]  b_caddr;
    logic        b_rstb, b_wstb;
    logic [15:0] b_cwd, b_crd;

    wbcsr_bridge #(.WB_DW(16), .CSR_DW(16), .WB_AW(4)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .wb_cyc(b_cyc), .wb_stb(b_stb), .wb_we(b_we),
        .wb_adr(b_adr), .wb_sel(b_sel), .wb_dat_w(b_dw), .wb_dat_r(b_dr), .wb_ack(b_ack),
        .csr_addr(b_caddr), .csr_r_stb(b_rstb), .csr_w_stb(b_wstb),
        .csr_w_data(b_cwd), .csr_r_data(b_crd)
    );

    logic [15:0] mem_b [16];
    int b_wcnt [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            b_crd <= '0;
            for (int i = 0; i < 16; i++) begin
                mem_b[i] <= '0; b_wcnt[i] <= 0;
            end
        end else begin
            if (b_wstb) begin
                mem_b[b_caddr] <= b_cwd;
                b_wcnt[b_caddr] <= b_wcnt[b_caddr] + 1;
            end
            if (b_rstb) b_crd <= mem_b[b_caddr];
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc_a(input logic w, input logic [3:0] a, input logic [3:0] s,
                         input logic [31:0] d, output logic [31:0] rd, output int lat);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; dw = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 40);
        rd = dr;
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic acc_b(input logic w, input logic [3:0] a, input logic [1:0] s,
                         input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        b_cyc = 1; b_stb = 1; b_we = w; b_adr = a; b_sel = s; b_dw = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!b_ack && lat < 40);
        rd = b_dr;
        b_cyc = 0; b_stb = 0; b_we = 0;
    endtask

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic        w;
        logic [3:0]  a;
        logic [3:0]  s;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1,  4'hF, 32'h44332211, 32'h0},
        '{1'b0, 4'd1,  4'hF, 32'h0,        32'h44332211},
        '{1'b1, 4'd1,  4'h6, 32'haabbccdd, 32'h0},
        '{1'b0, 4'd1,  4'hF, 32'h0,        32'h44bbcc11},
        '{1'b0, 4'd1,  4'h6, 32'h0,        32'h00bbcc00},
        '{1'b1, 4'd2,  4'h9, 32'h87654321, 32'h0},
        '{1'b0, 4'd2,  4'hF, 32'h0,        32'h87000021},
        '{1'b0, 4'd2,  4'h0, 32'h0,        32'h0},
        '{1'b1, 4'd15, 4'hF, 32'hdeadbeef, 32'h0},
        '{1'b0, 4'd15, 4'h1, 32'h0,        32'h000000ef},
        '{1'b1, 4'd2,  4'h0, 32'hffffffff, 32'h0}
    };

    initial begin
        logic [31:0] rd;
        logic [15:0] rdb;
        int lat;
        int base;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack", ack, 0);
        check("R1 strobes", rstb | wstb, 0);
        check("R1 dat_r", dr, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: stb without cyc, cyc without stb
        stb = 1; cyc = 0; we = 1; sel = 4'hF; dw = 32'h12345678;
        repeat (5) @(negedge clk);
        stb = 0; cyc = 1;
        repeat (5) @(negedge clk);
        cyc = 0; we = 0;
        check("R2 no strobe", any_stb, 0);
        check("R2 no ack", any_ack, 0);

        // table walk: R6, R7, R10
        for (int i = 0; i < NV; i++) begin
            acc_a(VECS[i].w, VECS[i].a, VECS[i].s, VECS[i].d, rd, lat);
            check(VECS[i].s == 4'h0 ? "R10 latency" : "R7 latency", lat, LAT_A);
            if (!VECS[i].w)
                check(VECS[i].s == 4'h0 ? "R10 dat_r" : "R6 dat_r", rd, VECS[i].exp);
        end

        // R4: write strobes only on selected lanes
        check("R4 wcnt4", wcnt[4], 1);
        check("R4 wcnt5", wcnt[5], 2);
        check("R4 wcnt7", wcnt[7], 1);
        check("R4 wcnt9", wcnt[9], 0);
        check("R10 wcnt8", wcnt[8], 1);
        check("R4 mem8 kept", mem[8], 8'h21);
        // R5: read strobes only on selected lanes
        check("R5 rcnt4", rcnt[4], 2);
        check("R5 rcnt5", rcnt[5], 3);
        check("R5 rcnt9", rcnt[9], 1);
        check("R5 rcnt61", rcnt[61], 0);
        check("R8 strobe overlap", viol, 0);

        // R3: lane order, addresses and consecutive cycles
        base = log_n;
        acc_a(1'b1, 4'd3, 4'hF, 32'h0d0c0b0a, rd, lat);
        check("R3 beats", log_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            check("R3 addr", log_addr[base + k], 12 + k);
            check("R3 cycle", log_tick[base + k] - log_tick[base], k);
            check("R3 data", mem[12 + k], 8'h0a + k);
        end
        acc_a(1'b0, 4'd3, 4'hC, 32'h0, rd, lat);
        check("R6 upper bytes", rd, 32'h0d0c0000);

        // R9: equal widths, direct mapping
        acc_b(1'b1, 4'd5, 2'b11, 16'h1234, rdb, lat);
        check("R9 latency", lat, LAT_B);
        check("R9 mem", mem_b[5], 16'h1234);
        check("R9 single beat", b_wcnt[5], 1);
        check("R9 neighbour", b_wcnt[4] + b_wcnt[6], 0);
        acc_b(1'b0, 4'd5, 2'b01, 16'h0, rdb, lat);
        check("R9 read low byte", rdb, 16'h0034);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule